// File: doc/BRIEF.md
# Two-Frame SPI Configuration Readback Slave

This block is an SPI slave that lets a host read one byte-wide configuration row in two steps. In the first chip-select frame the host shifts in a 16-bit request: a command, a row address and filler. Nothing comes back in that frame. In the next chip-select frame the slave shifts out a 16-bit reply. The reply holds seven zero filler bits, then the eight data bits of the requested row, then that row's parity bit.

The block runs on one system clock and oversamples the SPI pins through synchronizers. Two pads are shared:
- The data pad is the serial input during a request frame and the serial output during a reply frame. While chip select is idle, the pad carries the internal demodulated data signal.
- The clock pad is the serial clock input while chip select is active. While chip select is idle, it is an open-drain alert output that can only pull low.

The register rows are written through a parallel test-load port, and each row's parity bit is computed at write time.

Top module: `cfg_readback_slave`

## Requirements
- R1: A request frame has exactly 16 SCLK rising edges, with data taken most-significant bit first. The frame is valid when bits 15..13 hold the read code 3'b110 and bits 12..9 hold a row address. Bits 8..0 are ignored whatever their value. Raising CS after a valid request makes the next CS-low frame a reply frame.
- R2: A reply frame shifts out the 16-bit word {7'b0000000, row[7:0], parity}, most-significant bit first. The first bit is on the data pad before the first SCLK rising edge. Each following bit appears after an SCLK falling edge, so the host samples bit k at rising edge k+1.
- R3: The parity bit makes the 9-bit value {row, parity} have an odd number of ones. It is computed when the row is written through the test-load port.
- R4: A full 16-clock request whose command field is not 3'b110 leaves no read pending.
- R5: A request frame with fewer or more than 16 SCLK rising edges is discarded and leaves no read pending.
- R6: A reply frame cut short by CS rising before 16 clocks clears the pending read. The next frame is then a request frame.
- R7: A completed reply frame also clears the pending read. One request yields exactly one reply.
- R8: A read request for a row address of 8 or more leaves no read pending.
- R9: An SCLK high level present when CS falls is not treated as a clock. Edges are counted only after SCLK has been seen low inside the frame, so a high-to-low move at the start of a frame does not shift the reply.
- R10: While CS is high, the data pad is driven with the demodulated input. The clock pad pulls low exactly when the alert request is high. Both follow their inputs one system clock later.
- R11: While CS is low, the alert pull-down is released. The data pad is not driven during a request frame and is driven during a reply frame. The pads reach their new roles within SYNC_STAGES+2 system clocks of a CS edge.
- R12: After reset, with CS high, the data pad is driven low, the alert pull-down is off and no read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk_pad_i | input | 1 | Level seen on the shared clock/alert pad |
| sclk_pad_oe | output | 1 | Pull the clock/alert pad low (open-drain alert) |
| dat_pad_i | input | 1 | Level seen on the shared data pad |
| dat_pad_o | output | 1 | Value driven onto the data pad |
| dat_pad_oe | output | 1 | Output enable of the data pad |
| alert_req | input | 1 | Internal alert request, shown on the clock pad while CS is high |
| demod_in | input | 1 | Internal demodulated data, shown on the data pad while CS is high |
| tl_we | input | 1 | Test-load write strobe |
| tl_addr | input | 3 | Test-load row index |
| tl_data | input | 8 | Test-load row value |

## Verification
The assertions check the frame sequencing on every cycle:
- a read becomes pending only at the end of a request frame that counted exactly 16 edges;
- a reply frame starts only when a read is pending;
- the end of any reply frame, completed or cut short, clears the pending read;
- the alert pull-down is released whenever chip select is active.

Only the bench scenarios can show the rest, because these depend on whole bit streams seen at the pins:
- the bit order and alignment of the reply;
- the parity value;
- rejection of bad commands, bad addresses and wrong-length frames;
- immunity to a clock level present at the chip-select edge.

// File: rtl/cfg_readback_pkg.sv
package cfg_readback_pkg;
  // Request field layout and command code (positions decoded by the frame engine)
  localparam int FRAME_BITS = 16;
  localparam int CMD_W      = 3;
  localparam int ADDR_W     = 4;
  localparam logic [CMD_W-1:0] CMD_READ = 3'b110;

  // Odd parity: returned bit makes data plus parity contain an odd count of ones
  function automatic logic odd_parity8(input logic [7:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NUM_ROWS = 8,
  parameter int DATA_W   = 8,
  localparam int ROW_AW  = $clog2(NUM_ROWS),
  localparam int ROW_W   = DATA_W + 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_AW-1:0] raddr,
  output logic [ROW_W-1:0]  rdata
);
  // Row plus parity stored together; registered read for block RAM inference
  logic [ROW_W-1:0] mem [NUM_ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wdata, ~(^wdata)};
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfg_frame_engine.sv
module cfg_frame_engine
  import cfg_readback_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int DATA_W   = 8,
  localparam int ROW_AW  = $clog2(NUM_ROWS),
  localparam int ROW_W   = DATA_W + 1,
  localparam int FILL_W  = FRAME_BITS - ROW_W,
  localparam int CNT_W   = $clog2(FRAME_BITS + 2),
  localparam int CMD_LSB = FRAME_BITS - CMD_W,
  localparam int ADR_LSB = CMD_LSB - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [ROW_W-1:0]  row_q,
  output logic              res_frame,
  output logic              pending,
  output logic [ROW_AW-1:0] pend_addr,
  output logic              spi_bit,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

  logic                  cs_q, sclk_q, armed;
  logic [FRAME_BITS-1:0] in_sr, out_sr;
  logic                  in_frame, cs_fall, cs_rise, sclk_rise, sclk_fall, req_ok;
  logic [CMD_W-1:0]      req_cmd;
  logic [ADDR_W-1:0]     req_addr;

  assign cs_fall   = cs_act & ~cs_q;
  assign cs_rise   = ~cs_act & cs_q;
  assign in_frame  = cs_act & cs_q;
  // armed only after SCLK has been observed low inside the frame
  assign sclk_rise = in_frame & armed & sclk_s & ~sclk_q;
  assign sclk_fall = in_frame & armed & ~sclk_s & sclk_q;

  assign req_cmd  = in_sr[CMD_LSB +: CMD_W];
  assign req_addr = in_sr[ADR_LSB +: ADDR_W];
  assign req_ok   = (bit_cnt == CNT_FULL) && (req_cmd == CMD_READ) &&
                    (32'(req_addr) < NUM_ROWS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b0;
      sclk_q    <= 1'b0;
      armed     <= 1'b0;
      bit_cnt   <= '0;
      in_sr     <= '0;
      out_sr    <= '0;
      res_frame <= 1'b0;
      pending   <= 1'b0;
      pend_addr <= '0;
    end else begin
      cs_q   <= cs_act;
      sclk_q <= sclk_s;
      if (cs_fall) begin
        armed     <= 1'b0;
        bit_cnt   <= '0;
        res_frame <= pending;
        out_sr    <= {{FILL_W{1'b0}}, row_q};
      end else if (in_frame) begin
        if (!sclk_s) armed <= 1'b1;
        if (sclk_rise) begin
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
          if (!res_frame) in_sr <= {in_sr[FRAME_BITS-2:0], sdi_s};
        end
        if (sclk_fall && res_frame) out_sr <= {out_sr[FRAME_BITS-2:0], 1'b0};
      end else if (cs_rise) begin
        armed     <= 1'b0;
        res_frame <= 1'b0;
        if (res_frame) begin
          pending <= 1'b0;
        end else if (req_ok) begin
          pending   <= 1'b1;
          pend_addr <= req_addr[ROW_AW-1:0];
        end
      end
    end
  end

  assign spi_bit = out_sr[FRAME_BITS-1];
endmodule

// File: rtl/cfg_pad_mux.sv
module cfg_pad_mux (
  input  logic clk,
  input  logic rst,
  input  logic cs_act,
  input  logic res_frame,
  input  logic spi_bit,
  input  logic demod_in,
  input  logic alert_req,
  output logic sclk_oe,
  output logic dat_o,
  output logic dat_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_oe <= 1'b0;
      dat_o   <= 1'b0;
      dat_oe  <= 1'b1;
    end else if (!cs_act) begin
      sclk_oe <= alert_req;
      dat_o   <= demod_in;
      dat_oe  <= 1'b1;
    end else begin
      sclk_oe <= 1'b0;
      dat_o   <= spi_bit;
      dat_oe  <= res_frame;
    end
  end
endmodule

// File: rtl/cfg_readback_slave.sv
module cfg_readback_slave
  import cfg_readback_pkg::*;
#(
  parameter int NUM_ROWS    = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_AW     = $clog2(NUM_ROWS),
  localparam int CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk_pad_i,
  output logic              sclk_pad_oe,
  input  logic              dat_pad_i,
  output logic              dat_pad_o,
  output logic              dat_pad_oe,
  input  logic              alert_req,
  input  logic              demod_in,
  input  logic              tl_we,
  input  logic [ROW_AW-1:0] tl_addr,
  input  logic [DATA_W-1:0] tl_data
);
  logic [2:0]          sync_q;
  logic                cs_act, sclk_s, sdi_s;
  logic                res_frame, pending, spi_bit;
  logic [ROW_AW-1:0]   pend_addr;
  logic [DATA_W:0]     row_q;
  logic [CNT_W-1:0]    bit_cnt;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, sclk_pad_i, dat_pad_i}),
    .q(sync_q)
  );
  assign cs_act = ~sync_q[2];
  assign sclk_s = sync_q[1];
  assign sdi_s  = sync_q[0];

  cfg_regfile #(.NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W)) u_rows (
    .clk(clk), .we(tl_we), .waddr(tl_addr), .wdata(tl_data),
    .raddr(pend_addr), .rdata(row_q)
  );

  cfg_frame_engine #(.NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .row_q(row_q), .res_frame(res_frame), .pending(pending),
    .pend_addr(pend_addr), .spi_bit(spi_bit), .bit_cnt(bit_cnt)
  );

  cfg_pad_mux u_pads (
    .clk(clk), .rst(rst), .cs_act(cs_act), .res_frame(res_frame),
    .spi_bit(spi_bit), .demod_in(demod_in), .alert_req(alert_req),
    .sclk_oe(sclk_pad_oe), .dat_o(dat_pad_o), .dat_oe(dat_pad_oe)
  );
endmodule

// File: rtl/cfg_readback_chk.sv
module cfg_readback_chk #(
  parameter int CNT_W      = 5,
  parameter int FRAME_BITS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_act,
  input logic             res_frame,
  input logic             pending,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sclk_pad_oe
);
  // R1: a read becomes pending only after exactly FRAME_BITS counted edges
  a_r1_full_request: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> (bit_cnt == CNT_W'(FRAME_BITS)));

  // R7: pending is raised only by the end of a request frame
  a_r7_pending_from_request: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> (!cs_act && !res_frame));

  // R2: a reply frame starts only when a read was pending
  a_r2_reply_needs_pending: assert property (@(posedge clk) disable iff (rst)
    $rose(res_frame) |-> $past(pending));

  // R6: any reply frame end clears the pending read
  a_r6_reply_end_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_act) && !cs_act && res_frame) |=> !pending);

  // R11: alert pull-down released while chip select is active
  a_r11_alert_off_in_frame: assert property (@(posedge clk) disable iff (rst)
    cs_act |=> !sclk_pad_oe);
endmodule

bind cfg_readback_slave cfg_readback_chk #(
  .CNT_W(CNT_W), .FRAME_BITS(cfg_readback_pkg::FRAME_BITS)
) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .res_frame(res_frame),
  .pending(pending), .bit_cnt(bit_cnt), .sclk_pad_oe(sclk_pad_oe)
);

// File: tb/cfg_readback_slave_tb.sv
module cfg_readback_slave_tb;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sclk_pad_i = 1'b0, dat_pad_i = 1'b0;
  logic       alert_req = 1'b0, demod_in = 1'b0;
  logic       tl_we = 1'b0;
  logic [2:0] tl_addr = '0;
  logic [7:0] tl_data = '0;
  logic       sclk_pad_oe, dat_pad_o, dat_pad_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_readback_slave u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_pad_i(sclk_pad_i),
    .sclk_pad_oe(sclk_pad_oe), .dat_pad_i(dat_pad_i), .dat_pad_o(dat_pad_o),
    .dat_pad_oe(dat_pad_oe), .alert_req(alert_req), .demod_in(demod_in),
    .tl_we(tl_we), .tl_addr(tl_addr), .tl_data(tl_data)
  );

  function automatic logic [7:0] row_val(input int i);
    return 8'((i * 37 + 5) ^ (i << 5));
  endfunction

  function automatic logic [15:0] reply_of(input logic [7:0] d);
    return {7'b0, d, ~(^d)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] tx, input int nclk, input bit glitch,
                       output logic [15:0] rx, output int oe_cnt);
    rx = '0; oe_cnt = 0;
    cs_n = 1'b0;
    if (glitch) sclk_pad_i = 1'b1;
    wt(H);
    if (glitch) begin sclk_pad_i = 1'b0; wt(H); end
    for (int i = 0; i < nclk; i++) begin
      dat_pad_i = (i < 16) ? tx[15-i] : 1'b0;
      wt(H);
      if (dat_pad_oe) oe_cnt++;
      rx = {rx[14:0], dat_pad_o};
      sclk_pad_i = 1'b1;
      wt(H);
      sclk_pad_i = 1'b0;
    end
    wt(H);
    cs_n = 1'b1;
    wt(2*H);
  endtask

  function automatic logic [15:0] req(input logic [2:0] c, input logic [3:0] a, input logic [8:0] f);
    return {c, a, f};
  endfunction

  // next frame must be a request: data pad never driven during it
  task automatic expect_no_pending(input string tag);
    logic [15:0] rx; int oe;
    frame(16'h0000, 16, 0, rx, oe);
    chk(tag, oe, 0);
  endtask

  task automatic t_reset();
    wt(3);
    chk("R12 data oe", dat_pad_oe, 1);
    chk("R12 data out", dat_pad_o, 0);
    chk("R12 alert oe", sclk_pad_oe, 0);
    expect_no_pending("R12 no pending");
  endtask

  task automatic t_load();
    for (int i = 0; i < 8; i++) begin
      tl_we = 1'b1; tl_addr = 3'(i); tl_data = row_val(i);
      wt(1);
    end
    tl_we = 1'b0;
    wt(2);
  endtask

  task automatic t_read(input int a, input logic [8:0] fill);
    logic [15:0] rx; int oe;
    frame(req(3'b110, 4'(a), fill), 16, 0, rx, oe);
    chk("R11 request not driven", oe, 0);
    frame(16'hFFFF, 16, 0, rx, oe);
    chk("R11 reply driven", oe, 16);
    chk("R1 R2 R3 reply word", rx, reply_of(row_val(a)));
    chk("R3 odd parity", ^{rx[8:0]}, 1);
    expect_no_pending("R7 one reply per request");
  endtask

  task automatic t_bad_cmd();
    logic [15:0] rx; int oe;
    frame(req(3'b010, 4'd2, 9'h000), 16, 0, rx, oe);
    expect_no_pending("R4 bad command");
    frame(req(3'b111, 4'd2, 9'h000), 16, 0, rx, oe);
    expect_no_pending("R4 bad command 111");
  endtask

  task automatic t_len();
    logic [15:0] rx; int oe;
    frame(req(3'b110, 4'd1, 9'h0), 12, 0, rx, oe);
    expect_no_pending("R5 short request");
    frame(req(3'b110, 4'd1, 9'h0), 17, 0, rx, oe);
    expect_no_pending("R5 long request");
  endtask

  task automatic t_abort_reply();
    logic [15:0] rx; int oe;
    frame(req(3'b110, 4'd4, 9'h0), 16, 0, rx, oe);
    frame(16'h0, 5, 0, rx, oe);
    chk("R6 aborted reply driven", oe, 5);
    expect_no_pending("R6 aborted reply clears");
  endtask

  task automatic t_bad_addr();
    logic [15:0] rx; int oe;
    frame(req(3'b110, 4'd9, 9'h0), 16, 0, rx, oe);
    expect_no_pending("R8 address 9");
  endtask

  task automatic t_glitch();
    logic [15:0] rx; int oe;
    frame(req(3'b110, 4'd3, 9'h0F0), 16, 1, rx, oe);
    frame(16'h0, 16, 1, rx, oe);
    chk("R9 reply aligned", rx, reply_of(row_val(3)));
  endtask

  task automatic t_pads();
    demod_in = 1'b1; alert_req = 1'b1; wt(3);
    chk("R10 demod shown", dat_pad_o, 1);
    chk("R10 alert pulls", sclk_pad_oe, 1);
    chk("R10 data oe idle", dat_pad_oe, 1);
    demod_in = 1'b0; alert_req = 1'b0; wt(3);
    chk("R10 demod low", dat_pad_o, 0);
    chk("R10 alert released", sclk_pad_oe, 0);
    alert_req = 1'b1;
    cs_n = 1'b0; wt(H);
    chk("R11 alert off in frame", sclk_pad_oe, 0);
    chk("R11 request pad input", dat_pad_oe, 0);
    cs_n = 1'b1; wt(H);
    chk("R10 alert back", sclk_pad_oe, 1);
    alert_req = 1'b0; wt(2*H);
  endtask

  initial begin
    wt(4);
    rst = 1'b0;
    t_reset();
    t_load();
    t_read(0, 9'h1AB);
    t_read(5, 9'h000);
    t_read(7, 9'h1FF);
    t_bad_cmd();
    t_len();
    t_abort_reply();
    t_bad_addr();
    t_glitch();
    t_pads();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule